// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block gives a clocked on-chip memory the pin behaviour of a 16-bit asynchronous static RAM. Control arrives on active-low pins: a chip select, an output enable, a write strobe and one byte-lane enable per 8-bit lane. The bidirectional data bus is split into an input word, an output word and one output-enable bit per lane, which the pad ring turns into tri-state drivers.

A fast system clock oversamples the pins through a short register chain. Each lane has its own write window, open while chip select, write strobe and that lane's enable are all low. The window closes when any one of the three goes inactive. The lane is then written with the address and data from the last sample in which the window was still open, because the data is referenced to the closing edge. The read path and the lane output enables are combinational from the pins and the current address, so a lane drives only while the truth table selects it for reading.

Top module: `sram_byte_lane_emu`

## Requirements
- R1: A write with be_n_i[0]=0 stores dq_i[7:0] into the low lane of the addressed word. With be_n_i[1]=1 the high lane of that word keeps its contents.
- R2: A write with be_n_i[1]=0 stores dq_i[15:8] into the high lane. With be_n_i[0]=1 the low lane keeps its contents.
- R3: dq_oe_o is 0 and dq_o is 0 while ce_n_i=1, while oe_n_i=1, while both bits of be_n_i are 1, or while ce_n_i=0 and we_n_i=0.
- R4: Lane i drives (dq_oe_o[i]=1) exactly when ce_n_i=0, oe_n_i=0, we_n_i=1 and be_n_i[i]=0. dq_o lane i then shows the stored byte at addr_i; a lane that is not driven shows 0 on dq_o.
- R5: A lane is written once per window. The write uses the address and data of the last sample in which the window was open. Address or data values that appear in the same sample as the closing edge are ignored. The result can be read within SYNC_STAGES+2 clock cycles after the closing edge.
- R6: A window is closed by a rise of we_n_i, by a rise of ce_n_i, or by a rise of that lane's bit in be_n_i.
- R7: The lanes have separate windows. When one lane's enable rises while the other lane stays in its window, each lane takes the data present just before its own closing edge.
- R8: When ce_n_i and we_n_i rise in the same cycle while oe_n_i=0, dq_oe_o stays 0 in that cycle and afterwards. The same holds when ce_n_i=0, oe_n_i=1 and we_n_i=1: the part is selected but drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_n_i | input | 1 | Active-low asynchronous reset of the sampling registers |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | DATA_W | Input side of the data bus |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write strobe, active low |
| be_n_i | input | LANES | Byte-lane enables, active low, bit 0 = bits 7:0 |
| dq_o | output | DATA_W | Output side of the data bus, 0 on undriven lanes |
| dq_oe_o | output | LANES | Per-lane driver enable for the data bus |

## Verification
The bench builds the block with ADDR_W=4 and SYNC_STAGES=2. The small address space lets a behavioural reference track every stored byte and compare both lanes on every clock. The two-stage sampling chain exercises the generated register chain rather than the single-flop variant, and it moves the commit two cycles after the closing edge. That makes the rule of using data from the previous sample visible against values that change at the closing edge.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE  = 2'd0,
      MODE_READ  = 2'd1,
      MODE_WRITE = 2'd2,
      MODE_MUTE  = 2'd3
   } mode_e;

   localparam int LANE_BITS = 8;

   function automatic mode_e decode_mode(input logic ce_n, input logic oe_n, input logic we_n);
      mode_e m;
      if (ce_n)       m = MODE_IDLE;
      else if (!we_n) m = MODE_WRITE;
      else if (oe_n)  m = MODE_MUTE;
      else            m = MODE_READ;
      return m;
   endfunction

endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16,
   parameter int LANES  = 2,
   parameter int STAGES = 1
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [LANES-1:0]  be_n_i,
   input  logic              we_n_i,
   input  logic              ce_n_i,
   output logic              cur_ce_n_o,
   output logic              cur_we_n_o,
   output logic [LANES-1:0]  cur_be_n_o,
   output logic              prv_ce_n_o,
   output logic              prv_we_n_o,
   output logic [LANES-1:0]  prv_be_n_o,
   output logic [ADDR_W-1:0] prv_addr_o,
   output logic [DATA_W-1:0] prv_data_o
);
   localparam int CTL_W = LANES + 2;
   localparam int SMP_W = ADDR_W + DATA_W + CTL_W;
   localparam logic [SMP_W-1:0] IDLE_SMP = {{(ADDR_W+DATA_W){1'b0}}, {CTL_W{1'b1}}};

   logic [SMP_W-1:0] raw_smp;
   logic [SMP_W-1:0] cur_smp;
   logic [SMP_W-1:0] prv_smp;

   assign raw_smp = {addr_i, data_i, be_n_i, we_n_i, ce_n_i};

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sram_pin_sampler: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) cur_smp <= IDLE_SMP;
            else          cur_smp <= raw_smp;
         end
      end else begin : g_chain
         logic [SMP_W-1:0] pipe [STAGES];
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) begin
               for (int k = 0; k < STAGES; k++) pipe[k] <= IDLE_SMP;
            end else begin
               pipe[0] <= raw_smp;
               for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            end
         end
         assign cur_smp = pipe[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) prv_smp <= IDLE_SMP;
      else          prv_smp <= cur_smp;
   end

   assign cur_ce_n_o = cur_smp[0];
   assign cur_we_n_o = cur_smp[1];
   assign cur_be_n_o = cur_smp[2 +: LANES];
   assign prv_ce_n_o = prv_smp[0];
   assign prv_we_n_o = prv_smp[1];
   assign prv_be_n_o = prv_smp[2 +: LANES];
   assign prv_data_o = prv_smp[CTL_W +: DATA_W];
   assign prv_addr_o = prv_smp[CTL_W+DATA_W +: ADDR_W];

endmodule

// File: rtl/sram_write_detect.sv
module sram_write_detect #(
   parameter int LANES = 2
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             cur_ce_n_i,
   input  logic             cur_we_n_i,
   input  logic [LANES-1:0] cur_be_n_i,
   input  logic             prv_ce_n_i,
   input  logic             prv_we_n_i,
   input  logic [LANES-1:0] prv_be_n_i,
   output logic [LANES-1:0] commit_o
);
   logic [LANES-1:0] win_cur;
   logic [LANES-1:0] win_prv;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         // a lane is open only while select, strobe and its own enable are all low
         assign win_cur[i]  = ~cur_ce_n_i & ~cur_we_n_i & ~cur_be_n_i[i];
         assign win_prv[i]  = ~prv_ce_n_i & ~prv_we_n_i & ~prv_be_n_i[i];
         assign commit_o[i] = win_prv[i] & ~win_cur[i];

         AST_SINGLE_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            commit_o[i] |=> !commit_o[i]); // R5
      end
   endgenerate

endmodule

// File: rtl/sram_lane_store.sv
module sram_lane_store #(
   parameter int ADDR_W = 10,
   parameter int WIDTH  = 8
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [WIDTH-1:0]  wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [WIDTH-1:0]  rd_data_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk_i) begin
      if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
   end

   assign rd_data_o = mem[rd_addr_i];

   AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      wr_en_i |=> mem[$past(wr_addr_i)] == $past(wr_data_i)); // R1

endmodule

// File: rtl/sram_read_gate.sv
module sram_read_gate
   import sram_emu_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic                       ce_n_i,
   input  logic                       oe_n_i,
   input  logic                       we_n_i,
   input  logic [LANES-1:0]           be_n_i,
   input  logic [LANES*LANE_BITS-1:0] rd_word_i,
   output logic [LANES*LANE_BITS-1:0] dq_o,
   output logic [LANES-1:0]           dq_oe_o
);
   mode_e mode;

   assign mode = decode_mode(ce_n_i, oe_n_i, we_n_i);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign dq_oe_o[i] = (mode == MODE_READ) && !be_n_i[i];
         assign dq_o[i*LANE_BITS +: LANE_BITS] =
            dq_oe_o[i] ? rd_word_i[i*LANE_BITS +: LANE_BITS] : '0;
      end
   endgenerate

endmodule

// File: rtl/sram_byte_lane_emu.sv
module sram_byte_lane_emu
   import sram_emu_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 1,
   localparam int LANES      = DATA_W / LANE_BITS
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] dq_i,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   input  logic              we_n_i,
   input  logic [LANES-1:0]  be_n_i,
   output logic [DATA_W-1:0] dq_o,
   output logic [LANES-1:0]  dq_oe_o
);
   generate
      if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr
         $error("sram_byte_lane_emu: ADDR_W out of range 1..24");
      end
      if (DATA_W % LANE_BITS != 0 || LANES < 1) begin : g_bad_width
         $error("sram_byte_lane_emu: DATA_W must be a non-zero multiple of 8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("sram_byte_lane_emu: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic              cur_ce_n, cur_we_n, prv_ce_n, prv_we_n;
   logic [LANES-1:0]  cur_be_n, prv_be_n;
   logic [ADDR_W-1:0] prv_addr;
   logic [DATA_W-1:0] prv_data;
   logic [LANES-1:0]  commit;
   logic [DATA_W-1:0] rd_word;

   sram_pin_sampler #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES),
      .STAGES (SYNC_STAGES)
   ) u_sampler (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .addr_i     (addr_i),
      .data_i     (dq_i),
      .be_n_i     (be_n_i),
      .we_n_i     (we_n_i),
      .ce_n_i     (ce_n_i),
      .cur_ce_n_o (cur_ce_n),
      .cur_we_n_o (cur_we_n),
      .cur_be_n_o (cur_be_n),
      .prv_ce_n_o (prv_ce_n),
      .prv_we_n_o (prv_we_n),
      .prv_be_n_o (prv_be_n),
      .prv_addr_o (prv_addr),
      .prv_data_o (prv_data)
   );

   sram_write_detect #(
      .LANES (LANES)
   ) u_detect (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .cur_ce_n_i (cur_ce_n),
      .cur_we_n_i (cur_we_n),
      .cur_be_n_i (cur_be_n),
      .prv_ce_n_i (prv_ce_n),
      .prv_we_n_i (prv_we_n),
      .prv_be_n_i (prv_be_n),
      .commit_o   (commit)
   );

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_store
         sram_lane_store #(
            .ADDR_W (ADDR_W),
            .WIDTH  (LANE_BITS)
         ) u_store (
            .clk_i     (clk_i),
            .rst_n_i   (rst_n_i),
            .wr_en_i   (commit[i]),
            .wr_addr_i (prv_addr),
            .wr_data_i (prv_data[i*LANE_BITS +: LANE_BITS]),
            .rd_addr_i (addr_i),
            .rd_data_o (rd_word[i*LANE_BITS +: LANE_BITS])
         );
      end
   endgenerate

   sram_read_gate #(
      .LANES (LANES)
   ) u_gate (
      .ce_n_i    (ce_n_i),
      .oe_n_i    (oe_n_i),
      .we_n_i    (we_n_i),
      .be_n_i    (be_n_i),
      .rd_word_i (rd_word),
      .dq_o      (dq_o),
      .dq_oe_o   (dq_oe_o)
   );

   AST_DESELECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ce_n_i |-> (dq_oe_o == '0)); // R3
   AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!ce_n_i && !we_n_i) |-> (dq_oe_o == '0 && dq_o == '0)); // R3
   AST_JOINT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ($rose(ce_n_i) && $rose(we_n_i)) |-> (dq_oe_o == '0)); // R8
   AST_COMMIT_AFTER_OPEN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (commit != '0) |-> $past(!ce_n_i && !we_n_i, SYNC_STAGES + 1)); // R6

endmodule

// File: tb/test_sram_byte_lane_emu.sv
`timescale 1ns/1ps
module test_sram_byte_lane_emu;
   localparam int AW   = 4;
   localparam int S    = 2;
   localparam int DW   = 16;
   localparam int CLK  = 8;
   localparam int DEP  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_i = '0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [1:0]    be_n = 2'b11;
   logic [DW-1:0] dq_o;
   logic [1:0]    dq_oe;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK/2) clk = ~clk;

   sram_byte_lane_emu #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(S)) i_sram_byte_lane_emu (
      .clk_i(clk), .rst_n_i(rst_n), .addr_i(addr), .dq_i(dq_i),
      .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n), .be_n_i(be_n),
      .dq_o(dq_o), .dq_oe_o(dq_oe));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference ----------------
   typedef struct packed {
      logic [AW-1:0] a;
      logic [15:0]   d;
      logic [1:0]    b;
      logic          w;
      logic          c;
   } smp_t;
   localparam smp_t IDLE = '{a: '0, d: '0, b: 2'b11, w: 1'b1, c: 1'b1};

   smp_t       hist[$];
   logic [7:0] mref [2][DEP];
   bit         known [2][DEP];

   function automatic bit lane_open(smp_t s, int i);
      return !s.c && !s.w && !s.b[i];
   endfunction

   always @(posedge clk) begin
      smp_t cs, ps, now;
      if (!rst_n) begin
         hist.delete();
         for (int k = 0; k <= S; k++) hist.push_back(IDLE);
      end else begin
         cs = hist[hist.size()-S];
         ps = hist[hist.size()-S-1];
         for (int i = 0; i < 2; i++) begin
            if (lane_open(ps, i) && !lane_open(cs, i)) begin
               mref[i][ps.a] = ps.d[i*8 +: 8];
               known[i][ps.a] = 1'b1;
            end
         end
         now = '{a: addr, d: dq_i, b: be_n, w: we_n, c: ce_n};
         hist.push_back(now);
         if (hist.size() > 16) void'(hist.pop_front());
      end
   end

   // per-cycle comparison against the reference
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
               logic eo;
               eo = !ce_n && !oe_n && we_n && !be_n[i];
               chk(dq_oe[i] == eo, "R4 lane enable vs truth table (R3)", 32'(dq_oe[i]), 32'(eo));
               if (!eo)
                  chk(dq_o[i*8 +: 8] == 8'h00, "R3 undriven lane zero", 32'(dq_o[i*8 +: 8]), 0);
               else if (known[i][addr])
                  chk(dq_o[i*8 +: 8] == mref[i][addr], "R4 read data vs model",
                      32'(dq_o[i*8 +: 8]), 32'(mref[i][addr]));
            end
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n);
      @(negedge clk);
      ce_n = 1; oe_n = 1; we_n = 1; be_n = 2'b11;
      repeat (n) @(negedge clk);
   endtask

   // how: 0 strobe ends, 1 select ends, 2 lane enables end
   task automatic wr(input logic [AW-1:0] a, input logic [1:0] b, input logic [15:0] d,
                     input int how, input logic [AW-1:0] a2, input logic [15:0] d2);
      @(negedge clk);
      addr = a; dq_i = d; be_n = b; oe_n = 1; we_n = 0; ce_n = 0;
      repeat (3) @(negedge clk);
      addr = a2; dq_i = d2;
      case (how)
         0: we_n = 1;
         1: ce_n = 1;
         default: be_n = 2'b11;
      endcase
      idle(S + 3);
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [1:0] b, input logic [15:0] exp, input string tag);
      @(negedge clk);
      addr = a; be_n = b; ce_n = 0; oe_n = 0; we_n = 1;
      #1;
      chk(dq_oe == ~b, tag, 32'(dq_oe), 32'(~b));
      chk(dq_o == exp, tag, 32'(dq_o), 32'(exp));
   endtask

   initial begin
      for (int i = 0; i < 2; i++)
         for (int k = 0; k < DEP; k++) known[i][k] = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(dq_oe == 2'b00, "R3 reset state enables", 32'(dq_oe), 0);
      chk(dq_o == 16'h0, "R3 reset state data", 32'(dq_o), 0);
      rst_n = 1;
      idle(3);

      // full word, ended by strobe
      wr(4'd1, 2'b00, 16'hA1B2, 0, 4'd1, 16'hA1B2);
      rd(4'd1, 2'b00, 16'hA1B2, "R4 full word read");
      // low lane only, ended by select
      wr(4'd1, 2'b10, 16'hCC55, 1, 4'd1, 16'hCC55);
      rd(4'd1, 2'b00, 16'hA155, "R1 low lane write keeps high lane");
      // high lane only, ended by lane enable
      wr(4'd1, 2'b01, 16'h7766, 2, 4'd1, 16'h7766);
      rd(4'd1, 2'b00, 16'h7755, "R2 high lane write keeps low lane (R6 enable end)");
      rd(4'd1, 2'b01, 16'h7700, "R4 upper lane only");
      rd(4'd1, 2'b10, 16'h0055, "R4 lower lane only");
      rd(4'd1, 2'b11, 16'h0000, "R3 both lane enables high");

      // closing-edge values are ignored
      wr(4'd3, 2'b00, 16'h0000, 0, 4'd3, 16'h0000);
      wr(4'd2, 2'b00, 16'h1234, 0, 4'd3, 16'hFFFF);
      rd(4'd2, 2'b00, 16'h1234, "R5 data from sample before close");
      rd(4'd3, 2'b00, 16'h0000, "R5 closing-edge address ignored");
      // select-ended window
      wr(4'd5, 2'b00, 16'h5A5A, 1, 4'd5, 16'h0F0F);
      rd(4'd5, 2'b00, 16'h5A5A, "R6 select rise ends write");

      // independent lane windows
      idle(1);
      addr = 4'd4; dq_i = 16'h1111; be_n = 2'b00; oe_n = 1; ce_n = 0; we_n = 0;
      repeat (3) @(negedge clk);
      be_n = 2'b10; dq_i = 16'h2222;
      repeat (3) @(negedge clk);
      we_n = 1; dq_i = 16'h3333;
      idle(S + 3);
      rd(4'd4, 2'b00, 16'h1122, "R7 lanes close independently");

      // output-disable modes
      @(negedge clk);
      addr = 4'd1; be_n = 2'b00; ce_n = 1; oe_n = 0; we_n = 1; #1;
      chk(dq_oe == 2'b00, "R3 deselected", 32'(dq_oe), 0);
      @(negedge clk);
      ce_n = 0; oe_n = 1; #1;
      chk(dq_oe == 2'b00, "R8 selected with outputs disabled", 32'(dq_oe), 0);
      @(negedge clk);
      oe_n = 0; we_n = 0; dq_i = 16'h9999; #1;
      chk(dq_oe == 2'b00, "R3 quiet during write", 32'(dq_oe), 0);
      @(negedge clk);
      ce_n = 1; we_n = 1; #1;
      chk(dq_oe == 2'b00, "R8 joint release stays quiet", 32'(dq_oe), 0);
      @(negedge clk); #1;
      chk(dq_oe == 2'b00, "R8 joint release next cycle", 32'(dq_oe), 0);
      idle(S + 3);
      rd(4'd1, 2'b00, 16'h9999, "R6 joint release commits write");

      idle(4);
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK * 20000);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule